// File: doc/BRIEF.md
# Fall-Through Single-Clock FIFO with Headroom Flag

This block is a first-in first-out buffer for one clock domain, built on an inferred two-port memory. A producer writes with a push strobe and a consumer removes words with a pop strobe. The two strobes are independent and may be asserted in the same cycle. The oldest stored word is already on the read-data output in every cycle that the not-empty flag is high. A consumer can therefore act on the word and pop it in that same cycle, with no extra cycle of read latency.

The depth is a parameter and need not be a power of two; the default is 100 words. The block also drives an almost-full flag that warns a producer ahead of the full condition. This flag comes from a dedicated counter that starts at the headroom margin (default 7), so the warning rises once seven or fewer free slots are left.

Two instances can be chained with no glue logic. The upstream not-empty output drives the downstream push, and the upstream read data drives the downstream write data. The downstream not-full output drives the upstream pop.

Top module: `sync_fwft_fifo`

## Requirements
- R1: A push accepted at a clock edge stores `wr_data` at that edge. Words leave the buffer in the same order they were accepted.
- R2: Whenever `not_empty` is 1, `rd_data` shows the oldest stored word. A push into an empty buffer raises `not_empty` in the next cycle, and `rd_data` then shows that word. `rd_data` does not change while `not_empty` is 1 and `pop` is 0.
- R3: A pop accepted at a clock edge removes the head word at that edge. In the next cycle `rd_data` shows the following word.
- R4: A push is accepted only when `not_full` is 1. A push while full is dropped, even if a pop is accepted in the same cycle.
- R5: A pop while `not_empty` is 0 is ignored. The pointers and occupancy do not change, so the next word pushed is the next word read.
- R6: An accepted push and an accepted pop in the same cycle leave the occupancy unchanged.
- R7: `almost_full` is 1 exactly when the occupancy is at least DEPTH minus AFULL_MARGIN (93 of 100 by default). It is therefore 1 whenever the buffer is full.
- R8: `not_full` is 0 exactly when the occupancy equals DEPTH, and `not_empty` is 0 exactly when it is 0. The full state persists while `pop` is 0, and the empty state persists while `push` is 0.
- R9: The read and write pointers wrap from DEPTH-1 to 0 by an explicit compare. Order is kept across many wraps for a depth that is not a power of two.
- R10: When `rst` is high at a clock edge, the buffer becomes empty: `not_empty`=0, `not_full`=1, `almost_full`=0. Words pushed before the reset are never read afterwards.
- R11: Two instances wired as a chain hold the sum of their depths. They deliver every word exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to store |
| pop | input | 1 | Remove-head strobe |
| rd_data | output | WIDTH | Oldest stored word, valid while not_empty is 1 |
| not_full | output | 1 | 1 when at least one free slot exists |
| not_empty | output | 1 | 1 when at least one word is stored |
| almost_full | output | 1 | 1 when AFULL_MARGIN or fewer free slots remain |

## Verification
The bench targets the edges of the occupancy range. It pushes while full, both alone and together with a pop. A design that let either of these through would overwrite the head or corrupt the count. It also pops while empty, where a careless design would move the read pointer and return stale words later. The almost-full flag is checked on every step across the 92/93 boundary, in both the filling and the draining direction, to catch an off-by-one in the headroom counter. Long runs through the 100-entry ring check the ordering, so a pointer that wraps on binary rollover or one slot late shows up as a wrong word. A two-stage chain is filled until both stages are full and then drained. A chain that lost or duplicated words at the full/empty hand-off would deliver a wrong count or a wrong order.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    typedef struct packed {
        logic full;
        logic empty;
        logic afull;
    } fifo_flag_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fifo_wrap_ptr.sv
module fifo_wrap_ptr #(
    parameter int unsigned DEPTH = 100,
    localparam int unsigned AW = fifo_pkg::idx_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] idx
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] idx;
    } ptr_state_t;

    ptr_state_t state_d, state_q;

    // Explicit compare against the last slot, so any depth works
    always_comb begin
        state_d = state_q;
        if (adv) begin
            if (state_q.idx == LAST)
                state_d.idx = '0;
            else
                state_d.idx = state_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign idx = state_q.idx;
endmodule

// File: rtl/fifo_level.sv
module fifo_level
    import fifo_pkg::*;
#(
    parameter int unsigned DEPTH        = 100,
    parameter int unsigned AFULL_MARGIN = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ok,
    input  logic       rd_ok,
    output fifo_flag_t flags
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned SW = $clog2(DEPTH + AFULL_MARGIN + 1);

    typedef struct packed {
        logic [CW-1:0] count;
        logic [SW-1:0] slack;   // occupancy plus margin, starts at the margin
        fifo_flag_t    flags;
    } level_state_t;

    level_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case ({wr_ok, rd_ok})
            2'b10: begin
                state_d.count = state_q.count + 1'b1;
                state_d.slack = state_q.slack + 1'b1;
            end
            2'b01: begin
                state_d.count = state_q.count - 1'b1;
                state_d.slack = state_q.slack - 1'b1;
            end
            default: ;
        endcase
        state_d.flags.empty = (state_d.count == '0);
        state_d.flags.full  = (state_d.count == CW'(DEPTH));
        state_d.flags.afull = (state_d.slack >= SW'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.count       <= '0;
            state_q.slack       <= SW'(AFULL_MARGIN);
            state_q.flags.empty <= 1'b1;
            state_q.flags.full  <= 1'b0;
            state_q.flags.afull <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags = state_q.flags;
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 100,
    localparam int unsigned AW = fifo_pkg::idx_width(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Unregistered read port gives the fall-through head word
    assign rdata = mem[raddr];
endmodule

// File: rtl/sync_fwft_fifo.sv
module sync_fwft_fifo
    import fifo_pkg::*;
#(
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned DEPTH        = 100,
    parameter int unsigned AFULL_MARGIN = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             not_full,
    output logic             not_empty,
    output logic             almost_full
);
    localparam int unsigned AW = idx_width(DEPTH);

    fifo_flag_t    flags;
    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_idx, rd_idx;

    assign wr_ok = push & ~flags.full;
    assign rd_ok = pop  & ~flags.empty;

    fifo_wrap_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
        .clk (clk), .rst (rst), .adv (wr_ok), .idx (wr_idx)
    );

    fifo_wrap_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
        .clk (clk), .rst (rst), .adv (rd_ok), .idx (rd_idx)
    );

    fifo_level #(.DEPTH(DEPTH), .AFULL_MARGIN(AFULL_MARGIN)) u_level (
        .clk (clk), .rst (rst), .wr_ok (wr_ok), .rd_ok (rd_ok), .flags (flags)
    );

    fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wr_idx),
        .wdata (wr_data),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    assign not_full    = ~flags.full;
    assign not_empty   = ~flags.empty;
    assign almost_full = flags.afull;
endmodule

// File: rtl/fifo_checker.sv
module fifo_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             push,
    input logic             pop,
    input logic [WIDTH-1:0] rd_data,
    input logic             not_full,
    input logic             not_empty,
    input logic             almost_full
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!not_empty && not_full && !almost_full)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!not_full && !pop) |=> !not_full); // R8

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!not_empty && !push) |=> !not_empty); // R8

    AST_FULL_WARNED: assert property (@(posedge clk) disable iff (rst)
        !not_full |-> almost_full); // R7

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (!not_empty && push) |=> not_empty); // R2

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (not_empty && !pop) |=> $stable(rd_data)); // R2

    AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (not_empty && not_full && push && pop) |=> (not_empty && not_full)); // R6

    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!not_empty && pop && !push) |=> !not_empty); // R5
endmodule

bind sync_fwft_fifo fifo_checker #(.WIDTH(WIDTH)) u_fifo_checker (
    .clk         (clk),
    .rst         (rst),
    .push        (push),
    .pop         (pop),
    .rd_data     (rd_data),
    .not_full    (not_full),
    .not_empty   (not_empty),
    .almost_full (almost_full)
);

// File: tb/tb_sync_fwft_fifo.sv
module tb_sync_fwft_fifo;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push = 1'b0, pop = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       not_full, not_empty, almost_full;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_fwft_fifo #(.WIDTH(8), .DEPTH(100), .AFULL_MARGIN(7)) dut (
        .clk, .rst, .push, .wr_data, .pop, .rd_data,
        .not_full, .not_empty, .almost_full
    );

    // Two-stage chain, depth 5 each
    logic       c_push = 1'b0, c_pop = 1'b0;
    logic [7:0] c_wdata = '0;
    logic [7:0] a_rd, b_rd;
    logic       a_nf, a_ne, a_af, b_nf, b_ne, b_af;

    sync_fwft_fifo #(.WIDTH(8), .DEPTH(5), .AFULL_MARGIN(2)) dut_a (
        .clk, .rst, .push(c_push), .wr_data(c_wdata), .pop(b_nf),
        .rd_data(a_rd), .not_full(a_nf), .not_empty(a_ne), .almost_full(a_af)
    );
    sync_fwft_fifo #(.WIDTH(8), .DEPTH(5), .AFULL_MARGIN(2)) dut_b (
        .clk, .rst, .push(a_ne), .wr_data(a_rd), .pop(c_pop),
        .rd_data(b_rd), .not_full(b_nf), .not_empty(b_ne), .almost_full(b_af)
    );

    typedef struct packed {
        logic       push;
        logic       pop;
        logic [7:0] din;
        logic       ne;
        logic       nf;
        logic       af;
        logic [7:0] dout;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'hA1, 1'b1, 1'b1, 1'b0, 8'hA1},
        '{1'b1, 1'b0, 8'hB2, 1'b1, 1'b1, 1'b0, 8'hA1},
        '{1'b1, 1'b0, 8'hC3, 1'b1, 1'b1, 1'b0, 8'hA1},
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'hB2},
        '{1'b1, 1'b1, 8'hD4, 1'b1, 1'b1, 1'b0, 8'hC3},
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'hD4},
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
        '{1'b1, 1'b0, 8'hE5, 1'b1, 1'b1, 1'b0, 8'hE5},
        '{1'b1, 1'b1, 8'hF6, 1'b1, 1'b1, 1'b0, 8'hF6},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hF6},
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic q, input logic [7:0] d);
        @(negedge clk);
        push = p; pop = q; wr_data = d;
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0;
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        report();
    end

    initial begin
        int sent;
        int recv;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R10: reset state
        chk("R10 reset not_empty", 32'(not_empty), 0);
        chk("R10 reset not_full", 32'(not_full), 1);
        chk("R10 reset almost_full", 32'(almost_full), 0);

        // Vector table: R1 R2 R3 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].push, VECS[i].pop, VECS[i].din);
            chk($sformatf("R2 vec%0d not_empty", i), 32'(not_empty), 32'(VECS[i].ne));
            chk($sformatf("R8 vec%0d not_full", i), 32'(not_full), 32'(VECS[i].nf));
            chk($sformatf("R7 vec%0d almost_full", i), 32'(almost_full), 32'(VECS[i].af));
            if (VECS[i].ne)
                chk($sformatf("R1 R3 vec%0d rd_data", i), 32'(rd_data), 32'(VECS[i].dout));
        end

        // Fill to full: R7 boundary, R8 full, R2 head stable
        for (int i = 1; i <= 100; i++) begin
            step(1'b1, 1'b0, 8'(i));
            chk($sformatf("R7 fill %0d almost_full", i), 32'(almost_full), 32'(i >= 93));
            chk($sformatf("R8 fill %0d not_full", i), 32'(not_full), 32'(i < 100));
            chk($sformatf("R2 fill %0d head", i), 32'(rd_data), 1);
        end

        // R4: push while full dropped
        step(1'b1, 1'b0, 8'hEE);
        chk("R4 push at full keeps full", 32'(not_full), 0);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0, 8'h00);
            chk("R8 full holds without pop", 32'(not_full), 0);
        end

        // R4: push+pop at full: only the pop is taken
        step(1'b1, 1'b1, 8'h99);
        chk("R4 push+pop at full not_full", 32'(not_full), 1);
        chk("R3 head after pop", 32'(rd_data), 2);

        // R6: push+pop at occupancy 99
        step(1'b1, 1'b1, 8'h77);
        chk("R6 level kept not_full", 32'(not_full), 1);
        chk("R6 level kept almost_full", 32'(almost_full), 1);
        chk("R3 head after second pop", 32'(rd_data), 3);

        // Drain: R1 order, R9 wrap, R7 falling boundary
        for (int k = 0; k < 99; k++) begin
            chk($sformatf("R9 drain %0d data", k), 32'(rd_data), (k < 98) ? 32'(3 + k) : 32'h77);
            step(1'b0, 1'b1, 8'h00);
            chk($sformatf("R7 drain %0d almost_full", k), 32'(almost_full), 32'((98 - k) >= 93));
            chk($sformatf("R8 drain %0d not_empty", k), 32'(not_empty), 32'((98 - k) > 0));
        end

        // R5: pop while empty ignored
        step(1'b0, 1'b1, 8'h00);
        chk("R5 pop at empty", 32'(not_empty), 0);
        step(1'b0, 1'b0, 8'h00);
        chk("R8 empty holds without push", 32'(not_empty), 0);
        step(1'b1, 1'b0, 8'h55);
        chk("R5 next push read next", 32'(rd_data), 32'h55);
        step(1'b0, 1'b1, 8'h00);

        // R10: reset mid-operation
        step(1'b1, 1'b0, 8'h11);
        step(1'b1, 1'b0, 8'h22);
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        chk("R10 mid reset not_empty", 32'(not_empty), 0);
        chk("R10 mid reset not_full", 32'(not_full), 1);
        chk("R10 mid reset almost_full", 32'(almost_full), 0);
        @(negedge clk) rst = 1'b0;
        step(1'b1, 1'b0, 8'h33);
        chk("R10 no stale data", 32'(rd_data), 32'h33);

        // R11: chained pair
        sent = 0;
        for (int cyc = 0; cyc < 40 && sent < 10; cyc++) begin
            @(negedge clk);
            c_push = a_nf;
            c_wdata = 8'(sent + 1);
            @(posedge clk); #1;
            if (c_push) sent++;
        end
        c_push = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R11 chain words sent", 32'(sent), 10);
        chk("R11 chain upstream full", 32'(a_nf), 0);
        chk("R11 chain downstream full", 32'(b_nf), 0);
        recv = 0;
        for (int cyc = 0; cyc < 80 && recv < 10; cyc++) begin
            @(negedge clk);
            if (b_ne) begin
                chk($sformatf("R11 chain word %0d", recv), 32'(b_rd), 32'(recv + 1));
                c_pop = 1'b1;
                recv++;
            end else begin
                c_pop = 1'b0;
            end
            @(posedge clk); #1;
        end
        c_pop = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 chain words received", 32'(recv), 10);
        chk("R11 chain empty after drain", 32'(b_ne), 0);

        report();
    end
endmodule